// File: doc/BRIEF.md
# Page Attribute Table Register Unit

This unit keeps a 64-bit table of eight memory-type slots and gives it two faces. Software reaches it through a register bus that carries an address and 64 bits of data. Every write is checked in full before it lands. If any slot carries an illegal code, or sets a bit that must stay zero, the table keeps its old contents and the unit raises a one-cycle fault pulse. A read returns the stored table on the cycle after the read strobe.

The second face is a combinational lookup for the page-walk logic. It takes the three attribute bits from a page entry (`pg_pat`, `pg_cd`, `pg_wt`) and uses them together as a slot index. It returns that slot's 3-bit memory type. A paging-enabled input gates the valid flag of the lookup. The unit has no enable bit of its own.

Top module: `pat_reg_unit`

## Requirements
- R1: After reset the table holds 0x0007040600070406, and `fault` and `rd_valid` are low.
- R2: The unit responds only at register address 0x277. A read or write at any other address leaves the table unchanged, raises no fault and gives no read response.
- R3: Slot k sits in bits 8k+7:8k, for k = 0..7. Bits 2:0 of a slot hold the memory type and bits 7:3 must be zero.
- R4: The legal type codes are 0 (UC), 1 (WC), 4 (WT), 5 (WP), 6 (WB) and 7 (UC-). A write whose slots all hold legal codes with zero upper bits replaces the whole table on the next clock edge.
- R5: A write in which any slot holds code 2 or 3, or has any of bits 7:3 set, leaves every bit of the table unchanged.
- R6: A rejected write to 0x277 drives `fault` high for exactly the one cycle after the write strobe. An accepted write leaves `fault` low.
- R7: A read strobe at 0x277 drives `rd_valid` high and `rd_data` to the stored table in the following cycle. A read issued in the cycle after a write returns the newly written value.
- R8: The lookup index is `pg_pat`*4 + `pg_cd`*2 + `pg_wt`. `mem_type` is bits 2:0 of that slot, and it follows a table update and input changes without delay.
- R9: When `paging_en` is low, `mem_type` reports slot 0 and `mem_type_valid` is low. When `paging_en` is high, `mem_type_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 32 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 64 | Write data |
| rd_data | output | 64 | Read data, registered |
| rd_valid | output | 1 | Read data valid pulse |
| fault | output | 1 | Protection-fault pulse for a rejected write |
| paging_en | input | 1 | Paging enabled |
| pg_pat | input | 1 | Page-entry attribute index bit |
| pg_cd | input | 1 | Page-entry cache-disable bit |
| pg_wt | input | 1 | Page-entry write-through bit |
| mem_type | output | 3 | Selected memory type |
| mem_type_valid | output | 1 | Lookup valid (paging enabled) |

## Verification
A corrupted table bit reaches the ports in two ways. It changes `mem_type` at once for the index that selects the slot holding that bit. It also shows in `rd_data` one cycle after a read. A wrong acceptance decision is caught in three places: the fault pulse on the cycle after the strobe, a readback, and a lookup of the slot that should not have changed. The bench therefore follows each write with a readback and with a sweep of all eight lookup indices. This catches a slot misplaced by a wrong byte offset.

// File: rtl/pat_reg_unit.sv
module pat_reg_unit #(
  parameter int          ADDR_W    = 32,
  parameter int          SLOTS     = 8,
  parameter int          SLOT_W    = 8,
  parameter int          TYPE_W    = 3,
  parameter logic [31:0] REG_ADDR  = 32'h277,
  parameter logic [63:0] RESET_VAL = 64'h0007040600070406
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       rd_data,
  output logic              rd_valid,
  output logic              fault,
  input  logic              paging_en,
  input  logic              pg_pat,
  input  logic              pg_cd,
  input  logic              pg_wt,
  output logic [TYPE_W-1:0] mem_type,
  output logic              mem_type_valid
);
  localparam int IDX_W = $clog2(SLOTS);

  logic [63:0]      table_q;
  logic [SLOTS-1:0] slot_bad;
  logic             hit, wr_ok;
  logic [IDX_W-1:0] idx;

  for (genvar k = 0; k < SLOTS; k++) begin : g_chk
    logic [SLOT_W-1:0] s;
    assign s = reg_wdata[k*SLOT_W +: SLOT_W];
    assign slot_bad[k] = (|s[SLOT_W-1:TYPE_W]) || (s[TYPE_W-1:0] == 3'd2) || (s[TYPE_W-1:0] == 3'd3);
  end

  assign hit   = (reg_addr == REG_ADDR[ADDR_W-1:0]);
  assign wr_ok = ~|slot_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      table_q  <= RESET_VAL;
      fault    <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      fault    <= reg_wr && hit && !wr_ok;
      rd_valid <= reg_rd && hit;
      if (reg_rd && hit) rd_data <= table_q;
      if (reg_wr && hit && wr_ok) table_q <= reg_wdata;
    end
  end

  assign idx            = paging_en ? {pg_pat, pg_cd, pg_wt} : '0;
  assign mem_type       = table_q[idx*SLOT_W +: TYPE_W];
  assign mem_type_valid = paging_en;

  assert_table_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(reg_wr) && $past(hit) && !$past(wr_ok) |-> $stable(table_q));
  assert_fault_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault || ($past(reg_wr) && $past(hit)));
  assert_foreign_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(hit) |-> $stable(table_q) && !fault && !rd_valid);
  assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && hit && wr_ok |=> table_q == $past(reg_wdata));
  assert_lookup_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !paging_en |-> !mem_type_valid && mem_type == table_q[TYPE_W-1:0]);
endmodule

// File: tb/test_pat_reg_unit.sv
module test_pat_reg_unit;
  logic clk = 0, rst_n = 0;
  logic [31:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [63:0] reg_wdata = 0, rd_data;
  logic rd_valid, fault, paging_en = 0, pg_pat = 0, pg_cd = 0, pg_wt = 0, mem_type_valid;
  logic [2:0] mem_type;
  int checks = 0, errors = 0;
  logic [63:0] model;

  always #5 clk = ~clk;

  pat_reg_unit i_pat_reg_unit (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] a, logic [63:0] d, output logic f);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0; f = fault;
    @(negedge clk); chk("R6 one-cycle fault", fault, 0);
  endtask

  task automatic rd(logic [31:0] a, output logic [63:0] d, output logic v);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    @(negedge clk); reg_rd = 0; d = rd_data; v = rd_valid;
  endtask

  task automatic sweep(string req);
    paging_en = 1;
    for (int i = 0; i < 8; i++) begin
      {pg_pat, pg_cd, pg_wt} = i[2:0];
      #1 chk(req, mem_type, model[i*8 +: 3]);
      chk("R9 valid", mem_type_valid, 1);
    end
  endtask

  task automatic t_reset;
    logic [63:0] d; logic v;
    chk("R1 fault", fault, 0); chk("R1 rd_valid", rd_valid, 0);
    rd(32'h277, d, v);
    chk("R1 value", d, 64'h0007040600070406); chk("R7 valid", v, 1);
    sweep("R8 reset lookup");
  endtask

  task automatic t_good(logic [63:0] val);
    logic f; logic [63:0] d; logic v;
    wr(32'h277, val, f); model = val;
    chk("R4 no fault", f, 0);
    rd(32'h277, d, v); chk("R4 R3 stored", d, val);
    sweep("R8 lookup");
  endtask

  task automatic t_bad(logic [63:0] val);
    logic f; logic [63:0] d; logic v;
    wr(32'h277, val, f);
    chk("R6 fault", f, 1);
    rd(32'h277, d, v); chk("R5 unchanged", d, model);
    sweep("R5 lookup unchanged");
  endtask

  task automatic t_addr;
    logic f; logic [63:0] d; logic v;
    wr(32'h276, 64'h0101010101010101, f); chk("R2 no fault", f, 0);
    wr(32'h278, 64'h0202020202020202, f); chk("R2 no fault on bad data", f, 0);
    rd(32'h1277, d, v); chk("R2 no read", v, 0);
    rd(32'h277, d, v); chk("R2 unchanged", d, model);
  endtask

  task automatic t_rd_after_wr;
    @(negedge clk); reg_addr = 32'h277; reg_wdata = 64'h0504010007060504; reg_wr = 1;
    @(negedge clk); reg_wr = 0; reg_rd = 1;
    @(negedge clk); reg_rd = 0;
    model = 64'h0504010007060504;
    chk("R7 back-to-back", rd_data, model); chk("R7 valid", rd_valid, 1);
  endtask

  task automatic t_paging_off;
    paging_en = 0;
    for (int i = 0; i < 8; i++) begin
      {pg_pat, pg_cd, pg_wt} = i[2:0];
      #1 chk("R9 slot0", mem_type, model[2:0]); chk("R9 invalid", mem_type_valid, 0);
    end
  endtask

  initial begin
    #200000; errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model = 64'h0007040600070406;
    repeat (3) @(negedge clk); rst_n = 1;
    t_reset;
    t_good(64'h0706050401000706);
    t_good(64'h0001040506070001);
    t_bad(64'h0706050403000706);
    t_bad(64'h0200000000000000);
    t_bad(64'h0000000000000008);
    t_bad(64'h0000800000000000);
    t_addr;
    t_rd_after_wr;
    t_paging_off;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule